// File: doc/BRIEF.md
# Pin Event Line Router

This block sits in the system-configuration area of a chip and decides which GPIO port drives each of the sixteen shared external-interrupt lines. It takes a level from every pin of nine 16-pin ports and gives sixteen line outputs. Line `n` can follow pin `n` of exactly one port. A 4-bit select field for each line chooses that port. The select fields live in four selector registers on a simple 32-bit register bus.

Software sets the selector fields over the bus. From then on, each line output copies the chosen pin's level one clock later. Level changes on the ports that are not chosen are dropped. The register window also holds three more words. Two are a remap word and a peripheral-mode word, and both ignore writes. The third is a free 32-bit compensation-control word. Edge detection and masking happen downstream.

Top module: `pin_event_router`

## Requirements
- R1: After reset every register reads 0x00000000, every line output is 0, and every line follows pin `n` of port 0.
- R2: Each line has a select field. Line `n` uses the selector word at byte offset 0x08 + 4*(n/4), bits [4*(n%4)+3 : 4*(n%4)]. When that field holds a port number p in 0..8, line `n` takes the value of `pinLevel[p*16 + n]` at the next rising clock edge.
- R3: Level changes on a port that a line's field does not name leave that line unchanged.
- R4: While a line's field holds 9..15, that line holds its last value whatever the pins do.
- R5: A write to a selector word (offsets 0x08, 0x0C, 0x10, 0x14) stores bits [15:0]. Bits [31:16] read back as zero.
- R6: Writes to the remap word (0x00) and the peripheral-mode word (0x04) are ignored. Both read 0.
- R7: The compensation-control word (0x20) stores all 32 written bits and reads them back.
- R8: The window is 0x400 bytes and is decoded by `busAddr[9:2]`; bits [1:0] are ignored. Offsets 0x18, 0x1C and 0x24 to 0x3FC read 0, and writes to them change nothing.
- R9: A selector write takes effect one edge late. If a pin level and a selector write change in the same cycle, that edge uses the old selection, and the new selection applies from the next edge.
- R10: `busRdata` shows the addressed word in the same cycle while `busSel`=1 and `busWrite`=0. At all other times it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 10 | Byte offset within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle |
| pinLevel | input | 144 | Pin levels, index = port*16 + pin |
| lineOut | output | 16 | Routed interrupt lines, registered |

## Verification
Suppose a select field is stored wrongly, or is decoded at the wrong bit position. Then a line follows the wrong port. This shows at `lineOut` on the first edge after a pin of that port or of the intended port changes, and a read of the selector word shows it at once. Suppose the hold-on-invalid logic is wrong. Then a line moves on a port-0 change at the edge after that change. The bench changes foreign ports, writes out-of-range fields and moves a pin in the same cycle as a selector write, so each of these faults shows up within one or two cycles.

// File: rtl/pinRouterPkg.sv
package pinRouterPkg;

  localparam int NUM_LINES      = 16;
  localparam int FIELD_W        = 4;
  localparam int FIELDS_PER_REG = 4;
  localparam int NUM_SEL_REGS   = NUM_LINES / FIELDS_PER_REG;
  localparam int SEL_IDX_W      = $clog2(NUM_SEL_REGS);
  localparam int SEL_KEEP_W     = FIELDS_PER_REG * FIELD_W;
  localparam int DATA_W         = 32;

  // word indices inside the window (byte offset / 4)
  localparam int REMAP_WORD    = 0;
  localparam int PMODE_WORD    = 1;
  localparam int SEL_BASE_WORD = 2;
  localparam int COMP_WORD     = 8;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_REMAP,
    RD_PMODE,
    RD_SEL,
    RD_COMP
  } rdSrcE;

  typedef struct packed {
    logic                 selWe;
    logic [SEL_IDX_W-1:0] selIdx;
    logic                 compWe;
    rdSrcE                rdSrc;
  } ctrlStrobesT;

endpackage

// File: rtl/pinRouterCtrl.sv
module pinRouterCtrl
  import pinRouterPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobesT       strobes
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              isRead;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign isRead  = busSel && !busWrite;

  always_comb begin
    strobes        = '0;
    strobes.rdSrc  = RD_NONE;
    if (busSel) begin
      if (int'(wordIdx) == REMAP_WORD) begin
        if (isRead) strobes.rdSrc = RD_REMAP;
      end else if (int'(wordIdx) == PMODE_WORD) begin
        if (isRead) strobes.rdSrc = RD_PMODE;
      end else if (int'(wordIdx) >= SEL_BASE_WORD &&
                   int'(wordIdx) <  SEL_BASE_WORD + NUM_SEL_REGS) begin
        strobes.selIdx = SEL_IDX_W'(int'(wordIdx) - SEL_BASE_WORD);
        strobes.selWe  = busWrite;
        if (isRead) strobes.rdSrc = RD_SEL;
      end else if (int'(wordIdx) == COMP_WORD) begin
        strobes.compWe = busWrite;
        if (isRead) strobes.rdSrc = RD_COMP;
      end
    end
  end

endmodule

// File: rtl/pinRouterData.sv
module pinRouterData
  import pinRouterPkg::*;
#(
  parameter int NUM_PORTS = 9
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobesT                    strobes,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_PORTS*NUM_LINES-1:0] pinLevel,
  output logic [DATA_W-1:0]              rdata,
  output logic [NUM_LINES-1:0]           lineOut
);

  logic [DATA_W-1:0]     remapReg;
  logic [DATA_W-1:0]     pmodeReg;
  logic [DATA_W-1:0]     compReg;
  logic [SEL_KEEP_W-1:0] selReg [NUM_SEL_REGS];

  // remap and peripheral-mode words have no write path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remapReg <= '0;
      pmodeReg <= '0;
    end else begin
      remapReg <= remapReg;
      pmodeReg <= pmodeReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) compReg <= '0;
    else if (strobes.compWe) compReg <= wdata;
  end

  for (genvar r = 0; r < NUM_SEL_REGS; r++) begin : g_selReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) selReg[r] <= '0;
      else if (strobes.selWe && (int'(strobes.selIdx) == r))
        selReg[r] <= wdata[SEL_KEEP_W-1:0];
    end
  end

  always_comb begin
    case (strobes.rdSrc)
      RD_REMAP: rdata = remapReg;
      RD_PMODE: rdata = pmodeReg;
      RD_SEL:   rdata = DATA_W'(selReg[strobes.selIdx]);
      RD_COMP:  rdata = compReg;
      default:  rdata = '0;
    endcase
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int REG_IDX = n / FIELDS_PER_REG;
    localparam int FLD_LSB = (n % FIELDS_PER_REG) * FIELD_W;

    logic [FIELD_W-1:0] field;
    logic               portHit;
    logic               pickBit;
    logic               lineQ;

    assign field   = selReg[REG_IDX][FLD_LSB +: FIELD_W];
    assign portHit = int'(field) < NUM_PORTS;

    always_comb begin
      pickBit = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (int'(field) == p) pickBit = pinLevel[p*NUM_LINES + n];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) lineQ <= 1'b0;
      else if (portHit) lineQ <= pickBit;
    end

    assign lineOut[n] = lineQ;
  end

endmodule

// File: rtl/pin_event_router.sv
module pin_event_router
  import pinRouterPkg::*;
#(
  parameter int NUM_PORTS = 9,
  parameter int ADDR_W    = 10
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busSel,
  input  logic                           busWrite,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [DATA_W-1:0]              busWdata,
  output logic [DATA_W-1:0]              busRdata,
  input  logic [NUM_PORTS*NUM_LINES-1:0] pinLevel,
  output logic [NUM_LINES-1:0]           lineOut
);

  ctrlStrobesT strobes;

  pinRouterCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  pinRouterData #(.NUM_PORTS(NUM_PORTS)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wdata   (busWdata),
    .pinLevel(pinLevel),
    .rdata   (busRdata),
    .lineOut (lineOut)
  );

endmodule

// File: rtl/pinRouterChecker.sv
module pinRouterChecker
  import pinRouterPkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata
);

  logic [ADDR_W-3:0] wordIdx;
  logic              isRead;
  logic [DATA_W-1:0] compShadow;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign isRead  = busSel && !busWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) compShadow <= '0;
    else if (busSel && busWrite && int'(wordIdx) == COMP_WORD) compShadow <= busWdata;
  end

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |-> busRdata == '0);

  a_r6_fixed_words_zero: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && int'(wordIdx) < SEL_BASE_WORD) |-> busRdata == '0);

  a_r5_sel_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && int'(wordIdx) >= SEL_BASE_WORD &&
     int'(wordIdx) < SEL_BASE_WORD + NUM_SEL_REGS) |-> busRdata[DATA_W-1:SEL_KEEP_W] == '0);

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && int'(wordIdx) >= SEL_BASE_WORD + NUM_SEL_REGS &&
     int'(wordIdx) != COMP_WORD) |-> busRdata == '0);

  a_r7_comp_readback: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && int'(wordIdx) == COMP_WORD) |-> busRdata == compShadow);

endmodule

bind pin_event_router pinRouterChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busRdata(busRdata)
);

// File: tb/pin_event_router_bench.sv
`timescale 1ns/1ps
module pin_event_router_bench;

  localparam int PORTS = 9;
  localparam int LINES = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [PORTS*LINES-1:0] pinLevel = '0;
  logic [LINES-1:0] lineOut;

  int  checks = 0;
  int  failures = 0;
  bit  chk = 1'b0;
  bit  done = 1'b0;

  typedef struct {
    bit          isLine;
    logic [31:0] exp;
    string       tag;
  } itemT;
  itemT q[$];

  always #2.5 clk = ~clk;

  pin_event_router u_pin_event_router (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinLevel(pinLevel), .lineOut(lineOut)
  );

  // monitor: compares results against the queued expectations
  always @(negedge clk) begin
    if (chk) begin
      itemT it;
      logic [31:0] act;
      checks++;
      if (q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty act=none exp=none");
      end else begin
        it  = q.pop_front();
        act = it.isLine ? {16'h0, lineOut} : busRdata;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    busSel = 1'b0; busWrite = 1'b0; chk = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    step();
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string tag);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    q.push_back('{1'b0, e, tag});
    chk = 1'b1;
    step();
  endtask

  task automatic idleRd(input string tag);
    busAddr = 10'h020;
    q.push_back('{1'b0, 32'h0, tag});
    chk = 1'b1;
    step();
  endtask

  task automatic setPort(input int p, input logic [15:0] v);
    pinLevel[p*LINES +: LINES] = v;
  endtask

  task automatic expLines(input logic [15:0] e, input string tag);
    q.push_back('{1'b1, {16'h0, e}, tag});
    chk = 1'b1;
    step();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(); step();
    rstN = 1'b1;
    step();

    // R1 reset state
    rd(10'h000, 32'h0, "R1 remap reset");
    rd(10'h008, 32'h0, "R1 sel0 reset");
    rd(10'h014, 32'h0, "R1 sel3 reset");
    rd(10'h020, 32'h0, "R1 comp reset");
    expLines(16'h0000, "R1 lines reset");

    // R1 default port 0 routing
    setPort(0, 16'hA5C3); step();
    expLines(16'hA5C3, "R1 port0 default");

    // R3 foreign port ignored
    setPort(3, 16'hFFFF); step();
    expLines(16'hA5C3, "R3 port3 unselected");

    // R5/R2 lines 0..3 to port 3
    wr(10'h008, 32'hFFFF_3333);
    rd(10'h008, 32'h0000_3333, "R5 sel0 upper dropped");
    expLines(16'hA5CF, "R2 lines0-3 from port3");

    // R2 line 5 to port 8 (highest)
    setPort(8, 16'h0020);
    wr(10'h00C, 32'h0000_0080);
    rd(10'h00C, 32'h0000_0080, "R5 sel1 readback");
    expLines(16'hA5EF, "R2 line5 from port8");

    // R4 lines 14/15 with fields 9 and 12 hold
    wr(10'h014, 32'h0000_C900);
    rd(10'h014, 32'h0000_C900, "R5 sel3 readback");
    setPort(0, 16'h65C3); step();
    expLines(16'hA5EF, "R4 invalid field holds");

    // R6 ignored writes
    wr(10'h000, 32'hFFFF_FFFF);
    wr(10'h004, 32'h1234_5678);
    rd(10'h000, 32'h0, "R6 remap ignores write");
    rd(10'h004, 32'h0, "R6 pmode ignores write");

    // R7 compensation word
    wr(10'h020, 32'hDEAD_BEEF);
    rd(10'h020, 32'hDEAD_BEEF, "R7 comp readback");
    wr(10'h020, 32'h0F0F_0001);
    rd(10'h020, 32'h0F0F_0001, "R7 comp second value");

    // R8 unmapped offsets and low address bits
    wr(10'h018, 32'hFFFF_FFFF);
    wr(10'h01C, 32'hFFFF_FFFF);
    wr(10'h3FC, 32'hFFFF_FFFF);
    rd(10'h018, 32'h0, "R8 0x18 reads zero");
    rd(10'h3FC, 32'h0, "R8 0x3FC reads zero");
    rd(10'h024, 32'h0, "R8 0x24 reads zero");
    rd(10'h00A, 32'h0000_3333, "R8 low addr bits ignored");
    rd(10'h010, 32'h0, "R8 sel2 untouched");
    expLines(16'hA5EF, "R8 lines untouched");

    // R10 idle read data
    idleRd("R10 idle rdata zero");

    // R9 same-cycle selector write and pin change
    busSel = 1'b1; busWrite = 1'b1; busAddr = 10'h008; busWdata = 32'h0;
    setPort(3, 16'hFFF0);
    step();
    expLines(16'hA5E0, "R9 old selection on write edge");
    expLines(16'hA5E3, "R9 new selection next edge");

    step();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule